// File: doc/BRIEF.md
# Timeslot-Gated Pattern Error Meter

This block measures the bit error rate of a serial PCM test stream. A per-bit enable marks which bits take part in the test. It can mark the bits of a set of selected timeslots from either serial direction, or every bit when the whole channel is tested, framed or unframed. Bits with the enable low are skipped. The enabled bits, however far apart, are checked as one continuous sequence against an expected pattern. That pattern is one of three maximal-length pseudo-random sequences, a zero-limited variant, or a repeating 8-bit word.

The checker locks onto the incoming data by itself and counts mismatches only while it is locked. The measurement covers a window that is a programmable power of two of enabled bits. A host pulses `start_i` to begin a measurement. It then reads the error count and three status flags: locked, window complete and counter overflow.

Top module: `ber_meter`

## Requirements
- R1: A cycle with `en_i` low (and `start_i` low) changes no state: the error count, lock flag, window progress and done flag stay as they were, whatever `bit_i` carries.
- R2: The enabled bits form one continuous pattern sequence, however many disabled bits lie between them.
- R3: `pat_sel_i` selects the pattern by code: 0 gives x^4+x^3+1, 1 gives x^15+x^14+1, 2 gives x^23+x^18+1, 3 gives the zero-limited sequence and 4 gives the fixed word. Codes 5 to 7 also give the fixed word. Each polynomial means b[n] = b[n-a] xor b[n-b].
- R4: Code 3 is the x^20+x^17+1 sequence. Its output is forced to 1 whenever the previous 14 output bits were all 0.
- R5: In fixed-word mode, `fix_word_i` repeats with bit 7 sent first. The checker locks at any of the 8 starting rotations.
- R6: While unlocked, `in_sync_o` is low. It goes high after `SYNC_LEN` consecutive enabled bits match the prediction.
- R7: While locked, enabled bits are grouped into blocks of `LOSS_WIN`, starting at the first bit after lock. `LOSS_THR` mismatches within one block drop the lock. Fewer mismatches do not.
- R8: Each enabled mismatched bit adds exactly 1 to `err_cnt_o`, but only if the checker was locked when the bit arrived and the window is not yet complete.
- R9: The window is 2^(SCALE_BASE + min(`scale_i`,10)) enabled bits after start. `done_o` rises after the last bit of the window. Later bits are not counted, and the count is held until the next start.
- R10: `err_cnt_o` saturates at all ones. An error arriving at the maximum sets `ovf_o`, which stays set until the next start.
- R11: `start_i` clears the count, `done_o` and `ovf_o`, drops the lock and restarts the window.
- R12: After reset the count is 0 and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new measurement (one-cycle strobe) |
| bit_i | input | 1 | Serial PCM data bit |
| en_i | input | 1 | Bit belongs to the test (selected timeslot or whole channel) |
| pat_sel_i | input | 3 | Expected pattern code |
| fix_word_i | input | 8 | Fixed pattern word, bit 7 first |
| scale_i | input | 4 | Window exponent offset |
| err_cnt_o | output | CNT_W | Saturating error count |
| in_sync_o | output | 1 | Checker locked |
| done_o | output | 1 | Measurement window complete |
| ovf_o | output | 1 | Error counter overflowed |

## Verification
A history register that holds the wrong bit shows up as mismatches within 23 enabled bits. Those mismatches either keep `in_sync_o` from rising or raise `err_cnt_o` on a clean stream. An off-by-one in the window counter moves the rise of `done_o` by one enabled bit, or adds or drops a single counted error at the window edge. The bench samples both edges. If a disabled bit leaks into the shift history, gapped streams lose lock within one loss block, so `in_sync_o` falls.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam logic [2:0] SEL_P4   = 3'd0;
  localparam logic [2:0] SEL_P15  = 3'd1;
  localparam logic [2:0] SEL_P23  = 3'd2;
  localparam logic [2:0] SEL_QRSS = 3'd3;
  localparam int HIST_W    = 23;
  localparam int ZRUN_W    = 4;
  localparam int ZRUN_MAX  = 14;
endpackage

// File: rtl/ber_expect.sv
module ber_expect
  import ber_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       en_i,
  input  logic       bit_i,
  input  logic       locked_i,
  input  logic       mism_i,
  input  logic [2:0] pat_sel_i,
  input  logic [7:0] fix_word_i,
  output logic       exp_o
);
  logic [HIST_W-1:0] hist_q;
  logic [ZRUN_W-1:0] zrun_q;
  logic [2:0]        ph_q;
  logic              raw, is_fix, is_qrss, forced, push_bit, out_bit;

  always_comb begin
    is_fix  = 1'b0;
    is_qrss = 1'b0;
    case (pat_sel_i)
      SEL_P4:   raw = hist_q[3] ^ hist_q[2];
      SEL_P15:  raw = hist_q[14] ^ hist_q[13];
      SEL_P23:  raw = hist_q[22] ^ hist_q[17];
      SEL_QRSS: begin raw = hist_q[19] ^ hist_q[16]; is_qrss = 1'b1; end
      default:  begin raw = 1'b0; is_fix = 1'b1; end
    endcase
    forced   = is_qrss && (zrun_q >= ZRUN_W'(ZRUN_MAX));
    exp_o    = is_fix ? fix_word_i[3'd7 - ph_q] : (forced | raw);
    // locked: run free on prediction; hunting: load from the line
    push_bit = locked_i ? raw : bit_i;
    out_bit  = locked_i ? exp_o : bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      zrun_q <= '0;
      ph_q   <= '0;
    end else if (restart_i) begin
      hist_q <= '0;
      zrun_q <= '0;
      ph_q   <= '0;
    end else if (en_i) begin
      hist_q <= {hist_q[HIST_W-2:0], push_bit};
      if (out_bit)       zrun_q <= '0;
      else if (~&zrun_q) zrun_q <= zrun_q + 1'b1;
      // slip one rotation on a hunting mismatch
      ph_q <= (!locked_i && mism_i) ? ph_q + 3'd2 : ph_q + 3'd1;
    end
  end
endmodule

// File: rtl/ber_sync.sv
module ber_sync #(
  parameter int SYNC_LEN = 32,
  parameter int LOSS_WIN = 64,
  parameter int LOSS_THR = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  input  logic mism_i,
  output logic locked_o
);
  localparam int GW = $clog2(SYNC_LEN + 1);
  localparam int LW = $clog2(LOSS_WIN + 1);
  localparam int TW = $clog2(LOSS_THR + 1);

  logic [GW-1:0] good_q;
  logic [LW-1:0] lwin_q;
  logic [TW-1:0] lerr_q;
  logic          locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      good_q   <= '0;
      lwin_q   <= '0;
      lerr_q   <= '0;
    end else if (restart_i) begin
      locked_q <= 1'b0;
      good_q   <= '0;
      lwin_q   <= '0;
      lerr_q   <= '0;
    end else if (en_i) begin
      if (!locked_q) begin
        if (mism_i) good_q <= '0;
        else if (good_q == GW'(SYNC_LEN - 1)) begin
          locked_q <= 1'b1;
          good_q   <= '0;
          lwin_q   <= '0;
          lerr_q   <= '0;
        end else good_q <= good_q + 1'b1;
      end else begin
        if (mism_i && lerr_q == TW'(LOSS_THR - 1)) begin
          locked_q <= 1'b0;
          good_q   <= '0;
        end else if (lwin_q == LW'(LOSS_WIN - 1)) begin
          lwin_q <= '0;
          lerr_q <= '0;
        end else begin
          lwin_q <= lwin_q + 1'b1;
          lerr_q <= lerr_q + TW'(mism_i);
        end
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/ber_meas.sv
module ber_meas #(
  parameter int SCALE_BASE  = 21,
  parameter int SCALE_STEPS = 11,
  parameter int SCALE_W     = 4,
  parameter int CNT_W       = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               en_i,
  input  logic               mism_i,
  input  logic               locked_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]   err_cnt_o,
  output logic               done_o,
  output logic               ovf_o
);
  localparam int WW = SCALE_BASE + SCALE_STEPS;

  logic [SCALE_W-1:0] n_sel;
  logic [WW-1:0]      win_lim, win_q;
  logic [CNT_W-1:0]   err_q;
  logic               done_q, ovf_q, live, hit;

  always_comb begin
    n_sel   = (scale_i > SCALE_W'(SCALE_STEPS - 1)) ? SCALE_W'(SCALE_STEPS - 1) : scale_i;
    win_lim = WW'(1) << (SCALE_BASE + int'(n_sel));
    live    = en_i && !done_q;
    hit     = live && locked_i && mism_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (restart_i) begin
      win_q  <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (live) begin
        win_q  <= win_q + 1'b1;
        done_q <= (win_q + 1'b1) == win_lim;
      end
      if (hit) begin
        if (&err_q) ovf_q <= 1'b1;
        else        err_q <= err_q + 1'b1;
      end
    end
  end

  assign err_cnt_o = err_q;
  assign done_o    = done_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/ber_meter.sv
module ber_meter #(
  parameter int SCALE_BASE = 21,
  parameter int CNT_W      = 24,
  parameter int SYNC_LEN   = 32,
  parameter int LOSS_WIN   = 64,
  parameter int LOSS_THR   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_i,
  input  logic             en_i,
  input  logic [2:0]       pat_sel_i,
  input  logic [7:0]       fix_word_i,
  input  logic [3:0]       scale_i,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             in_sync_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic exp_bit, mism, locked;

  assign mism = bit_i ^ exp_bit;

  ber_expect u_exp (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_i), .en_i(en_i),
    .bit_i(bit_i), .locked_i(locked), .mism_i(mism),
    .pat_sel_i(pat_sel_i), .fix_word_i(fix_word_i), .exp_o(exp_bit)
  );

  ber_sync #(.SYNC_LEN(SYNC_LEN), .LOSS_WIN(LOSS_WIN), .LOSS_THR(LOSS_THR)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_i), .en_i(en_i),
    .mism_i(mism), .locked_o(locked)
  );

  ber_meas #(.SCALE_BASE(SCALE_BASE), .SCALE_STEPS(11), .SCALE_W(4), .CNT_W(CNT_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_i), .en_i(en_i),
    .mism_i(mism), .locked_i(locked), .scale_i(scale_i),
    .err_cnt_o(err_cnt_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  assign in_sync_o = locked;
endmodule

// File: rtl/ber_meter_chk.sv
module ber_meter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             en_i,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             in_sync_o,
  input logic             done_o,
  input logic             ovf_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> ($stable(err_cnt_o) && $stable(in_sync_o) && $stable(done_o))); // R1
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (err_cnt_o == '0 && !in_sync_o && !done_o && !ovf_o)); // R11
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (err_cnt_o == $past(err_cnt_o) || err_cnt_o == $past(err_cnt_o) + 1'b1)); // R8
  AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sync_o && !start_i) |=> $stable(err_cnt_o)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(err_cnt_o))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&err_cnt_o) && !start_i) |=> (&err_cnt_o)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !start_i) |=> ovf_o); // R10
  AST_OVF_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (&err_cnt_o)); // R10
endmodule

bind ber_meter ber_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .en_i(en_i),
  .err_cnt_o(err_cnt_o), .in_sync_o(in_sync_o), .done_o(done_o), .ovf_o(ovf_o)
);

// File: tb/sim_ber_meter.sv
module sim_ber_meter;
  localparam int CW   = 8;
  localparam int BASE = 4;
  localparam int NLEN = 16384;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni, start_i, bit_i, en_i;
  logic [2:0] pat_sel_i;
  logic [7:0] fix_word_i;
  logic [3:0] scale_i;
  logic [CW-1:0] err_cnt_o;
  logic in_sync_o, done_o, ovf_o;

  ber_meter #(.SCALE_BASE(BASE), .CNT_W(CW), .SYNC_LEN(32), .LOSS_WIN(64), .LOSS_THR(6)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bit_i(bit_i), .en_i(en_i),
    .pat_sel_i(pat_sel_i), .fix_word_i(fix_word_i), .scale_i(scale_i),
    .err_cnt_o(err_cnt_o), .in_sync_o(in_sync_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  int n_run = 0, n_fail = 0, n_forced = 0;
  bit strm [NLEN];
  bit raw  [NLEN];

  task automatic chk(string rq, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic push(bit b, bit e);
    bit_i = b; en_i = e;
    @(posedge clk_i); #1;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; en_i = 1'b0;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  // Expected stream built from the pattern definitions
  task automatic fill(int sel, logic [7:0] fw, int rot);
    int a, b, zr;
    if (sel >= 4) begin
      for (int k = 0; k < NLEN; k++) strm[k] = fw[7 - ((k + rot) % 8)];
    end else if (sel == 3) begin
      for (int k = 200; k < 220; k++) raw[k] = (k == 219);
      for (int n = 219; n >= 20; n--) raw[n-20] = raw[n] ^ raw[n-17];
      for (int n = 220; n < NLEN; n++) raw[n] = raw[n-20] ^ raw[n-17];
      zr = 0; n_forced = 0;
      for (int k = 0; k < NLEN; k++) begin
        if (zr >= 14) begin strm[k] = 1'b1; if (!raw[k]) n_forced++; end
        else strm[k] = raw[k];
        zr = strm[k] ? 0 : zr + 1;
      end
    end else begin
      a = (sel == 0) ? 4 : (sel == 1) ? 15 : 23;
      b = (sel == 0) ? 3 : (sel == 1) ? 14 : 18;
      for (int k = 0; k < NLEN; k++) strm[k] = (k < a) ? 1'b1 : strm[k-a] ^ strm[k-b];
    end
  endtask

  task automatic run_meas(int sel, logic [7:0] fw, int rot, int scale, bit gap,
                          int err_every, int nbits, string rq);
    int win, exp, capd;
    fill(sel, fw, rot);
    pat_sel_i = 3'(sel); fix_word_i = fw; scale_i = 4'(scale);
    pulse_start();
    win = 1 << (BASE + ((scale > 10) ? 10 : scale));
    exp = 0;
    for (int k = 0; k < nbits; k++) begin
      bit inj = 1'b0;
      if (gap && (k % 8 == 0))
        for (int g = 0; g < 5; g++) push(((k * 7 + g * 3) % 5) < 2, 1'b0);
      if (k == win - 1) chk({rq, " R9 done before last bit"}, int'(done_o), 0);
      if (in_sync_o && ((err_every > 0 && k % err_every == 0) || k == win)) begin
        inj = 1'b1;
        if (k < win) exp++;
      end
      push(strm[k] ^ inj, 1'b1);
    end
    capd = (exp > (1 << CW) - 1) ? (1 << CW) - 1 : exp;
    chk({rq, " R8 count"}, int'(err_cnt_o), capd);
    chk({rq, " R9 done"}, int'(done_o), int'(nbits >= win));
    chk({rq, " R6 locked"}, int'(in_sync_o), 1);
    chk({rq, " R10 ovf"}, int'(ovf_o), int'(exp > (1 << CW) - 1));
  endtask

  task automatic loss_test();
    int m, held;
    fill(1, 8'h00, 0);
    pat_sel_i = 3'd1; scale_i = 4'd6;
    pulse_start();
    m = 0;
    while (!in_sync_o && m < 200) begin push(strm[m], 1'b1); m++; end
    chk("R6 lock within 200 bits", int'(in_sync_o), 1);
    for (int j = 0; j < 80; j++) begin
      bit inj = (j >= 10 && j <= 14) || (j >= 74);
      if (j == 79) chk("R7 five errors keep lock", int'(in_sync_o), 1);
      push(strm[m] ^ inj, 1'b1); m++;
    end
    chk("R7 sixth error in block drops lock", int'(in_sync_o), 0);
    chk("R8 errors while locked", int'(err_cnt_o), 11);
    for (int j = 0; j < 150; j++) begin push(strm[m], 1'b1); m++; end
    chk("R6 relock", int'(in_sync_o), 1);
    chk("R8 no count while hunting", int'(err_cnt_o), 11);
    held = int'(err_cnt_o);
    for (int j = 0; j < 40; j++) push(j[0] ^ j[2], 1'b0);
    chk("R1 idle count", int'(err_cnt_o), held);
    chk("R1 idle lock", int'(in_sync_o), 1);
    chk("R1 idle done", int'(done_o), 0);
    // continue stream: disabled bits must not have shifted the history
    for (int j = 0; j < 64; j++) begin push(strm[m], 1'b1); m++; end
    chk("R1 stream resumes clean", int'(err_cnt_o), held);
    pulse_start();
    chk("R11 count cleared", int'(err_cnt_o), 0);
    chk("R11 lock dropped", int'(in_sync_o), 0);
    chk("R11 done cleared", int'(done_o), 0);
  endtask

  task automatic window_test(int scale, string rq);
    int win;
    fill(0, 8'h00, 0);
    pat_sel_i = 3'd0; scale_i = 4'(scale);
    pulse_start();
    win = 1 << (BASE + ((scale > 10) ? 10 : scale));
    for (int k = 0; k < win - 1; k++) push(strm[k], 1'b1);
    chk({rq, " done low at 2^N-1"}, int'(done_o), 0);
    push(strm[win-1], 1'b1);
    chk({rq, " done high at 2^N"}, int'(done_o), 1);
    chk({rq, " clean count"}, int'(err_cnt_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; bit_i = 1'b0; en_i = 1'b0;
    pat_sel_i = 3'd0; fix_word_i = 8'h00; scale_i = 4'd0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R12 reset count", int'(err_cnt_o), 0);
    chk("R12 reset lock", int'(in_sync_o), 0);
    chk("R12 reset done", int'(done_o), 0);
    chk("R12 reset ovf", int'(ovf_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    run_meas(0, 8'h00, 0, 3, 1'b0, 16, 140, "R3 p4");
    run_meas(1, 8'h00, 0, 3, 1'b0, 17, 140, "R3 p15");
    run_meas(2, 8'h00, 0, 4, 1'b0, 19, 270, "R3 p23");
    run_meas(1, 8'h00, 0, 3, 1'b1, 0, 128, "R2 gapped p15");
    run_meas(2, 8'h00, 0, 3, 1'b1, 16, 128, "R2 gapped p23");
    run_meas(3, 8'h00, 0, 4, 1'b0, 0, 260, "R4 qrss");
    chk("R4 stream has forced ones", int'(n_forced > 0), 1);
    run_meas(4, 8'hA7, 3, 3, 1'b0, 16, 140, "R5 fixed rot3");
    run_meas(4, 8'h1E, 6, 3, 1'b1, 0, 128, "R5 fixed gapped");
    run_meas(6, 8'h3C, 5, 3, 1'b0, 20, 128, "R3 code6 fixed");
    run_meas(4, 8'h1E, 0, 9, 1'b0, 16, 4600, "R10 saturate");
    loss_test();
    window_test(0, "R9 scale0");
    window_test(15, "R9 scale clamp");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule